// File: doc/BRIEF.md
# Processor Reset Vector Fetch Sequencer

This block brings a processor core out of reset. While the reset input is low it throws away whatever it was doing and holds the architectural control state at fixed values. The supervisor bit is set and the trace bit is cleared. The master bit is cleared and the interrupt mask is set to its top level. The vector base is zero and every attached memory controller is disabled.

When reset is released, the block first writes two hardware configuration words, set by parameters, into the two data register outputs. It then asks for the bus. Once the bus is granted it reads two 32-bit words from the vector table. The first word becomes the supervisor stack pointer and the second becomes the program counter. When both reads succeed, a one-cycle start strobe tells the core that it may begin executing at the program counter.

A bus error, a misaligned vector table address, or an odd program counter before that point puts the block into a terminal fault-on-fault state. Only a fresh reset leaves that state.

The read port is a valid/ready channel. `rd_stb` is the valid side. `rd_ready` is the normal completion and `rd_err` is the error completion. Back-pressure is unlimited: the master keeps `rd_addr` and `rd_stb` steady for as many cycles as the slave needs, and it never has more than one read open. A response is sampled only in a cycle where `rd_stb` is high. If `rd_err` and `rd_ready` arrive together, the error wins.

Top module: `reset_vector_seq`

## Requirements
- R1: While `rst_n` is low the outputs are forced at once, with no clock needed. `sr_o` reads 16'h2700: bit 15 (trace) is 0, bit 13 (supervisor) is 1, bit 12 (master) is 0, bits 10:8 (interrupt mask) are 3'b111, and all other bits are 0. `vbr_o`, `ssp_o`, `pc_o`, `d0_o`, `d1_o` and `mem_en_o` are all zero. `bus_req`, `rd_stb`, `start_exec` and `fof` are all low.
- R2: At the first rising clock edge after `rst_n` goes high, `d0_o` takes `CFG_D0` and `d1_o` takes `CFG_D1`. `bus_req` rises on that same edge, and no read has started yet.
- R3: `bus_req` stays high with `rd_stb` low until `bus_gnt` is sampled high. In the cycle after that edge, `rd_stb` is high and `rd_addr` equals `VEC_BASE`.
- R4: While `rd_stb` is high and neither `rd_ready` nor `rd_err` has been sampled, `rd_stb` stays high and `rd_addr` stays unchanged. Only one read is ever open at a time.
- R5: When the first read completes with `rd_ready` high and `rd_err` low, `ssp_o` takes `rd_data` on that edge. From the next cycle the second read is presented at `VEC_BASE`+4, and `rd_stb` does not drop in between.
- R6: When the second read completes without error and `rd_data[0]` is 0, `pc_o` takes `rd_data`. In the next cycle `start_exec` is high for exactly one cycle, and `bus_req` and `rd_stb` are low. After that the block stays idle.
- R7: If `rd_err` is sampled high during either read, `fof` goes high from the next cycle and stays high. `bus_req` and `rd_stb` drop, `start_exec` never pulses, and the register being fetched keeps its old value.
- R8: If the second read completes with `rd_data[0]` equal to 1, this is an address error. It has the same effect as R7, and `pc_o` stays 0.
- R9: If `VEC_BASE[1:0]` is nonzero, the grant leads straight to `fof` in the next cycle. `rd_stb` is never raised.
- R10: Pulling `rst_n` low at any step, including the fault state, aborts that step at once and restores the R1 values. The next release starts the whole sequence again from the first read.
- R11: `sr_o`, `vbr_o` and `mem_en_o` keep their R1 values throughout the sequence, whatever data the bus returns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Reset, active low, asynchronous assertion |
| bus_gnt | input | 1 | Bus grant from the arbiter |
| rd_data | input | AW | Read data |
| rd_ready | input | 1 | Read completed normally |
| rd_err | input | 1 | Read completed with access error |
| bus_req | output | 1 | Bus request, held through both reads |
| rd_stb | output | 1 | Read valid |
| rd_addr | output | AW | Read address |
| sr_o | output | 16 | Status register |
| vbr_o | output | AW | Vector base register |
| ssp_o | output | AW | Supervisor stack pointer |
| pc_o | output | AW | Program counter |
| d0_o | output | AW | Configuration data register 0 |
| d1_o | output | AW | Configuration data register 1 |
| mem_en_o | output | MEM_PORTS | Enables of attached memory controllers |
| start_exec | output | 1 | One-cycle start-execution strobe |
| fof | output | 1 | Fault-on-fault, sticky until reset |

## Verification
A wrong sequencer state shows at the bus port within one cycle. Examples are a strobe before grant, an address that moves while a read is waiting, a second read at the wrong offset, or a request still held after the start strobe. A wrong load enable leaves `ssp_o`, `pc_o` or the configuration registers different from the data that was presented, and this can be seen in the cycle after the accepted read. A bad error path shows up either as `fof` failing to rise in the cycle after the error, or as a start strobe that follows an error or an odd program counter.

// File: rtl/rvs_pkg.sv
package rvs_pkg;
  localparam int SR_W       = 16;
  localparam int SR_T_BIT   = 15;
  localparam int SR_S_BIT   = 13;
  localparam int SR_M_BIT   = 12;
  localparam int SR_IPL_LO  = 8;
  localparam int SR_IPL_W   = 3;

  typedef enum logic [2:0] {
    ST_RESET,
    ST_REQ,
    ST_RD_SSP,
    ST_RD_PC,
    ST_START,
    ST_RUN,
    ST_FOF
  } seq_state_t;

  function automatic logic [SR_W-1:0] sr_reset_value();
    logic [SR_W-1:0] v;
    v = '0;
    v[SR_T_BIT] = 1'b0;
    v[SR_S_BIT] = 1'b1;
    v[SR_M_BIT] = 1'b0;
    v[SR_IPL_LO +: SR_IPL_W] = {SR_IPL_W{1'b1}};
    return v;
  endfunction
endpackage

// File: rtl/rvs_bus_rd.sv
module rvs_bus_rd
  import rvs_pkg::*;
#(
  parameter int AW = 32,
  parameter logic [AW-1:0] VEC_BASE = '0
) (
  input  seq_state_t     state,
  input  logic           rd_ready,
  input  logic           rd_err,
  output logic           bus_req,
  output logic           rd_stb,
  output logic [AW-1:0]  rd_addr,
  output logic           xfer_ok,
  output logic           xfer_err,
  output logic           base_misaligned
);
  localparam logic [AW-1:0] SSP_ADDR = VEC_BASE;
  localparam logic [AW-1:0] PC_ADDR  = VEC_BASE + AW'(4);

  assign base_misaligned = |VEC_BASE[1:0];

  always_comb begin
    bus_req = 1'b0;
    rd_stb  = 1'b0;
    rd_addr = '0;
    case (state)
      ST_REQ:    bus_req = 1'b1;
      ST_RD_SSP: begin
        bus_req = 1'b1;
        rd_stb  = 1'b1;
        rd_addr = SSP_ADDR;
      end
      ST_RD_PC: begin
        bus_req = 1'b1;
        rd_stb  = 1'b1;
        rd_addr = PC_ADDR;
      end
      default: ;
    endcase
  end

  // error response takes priority over a simultaneous ready
  assign xfer_err = rd_stb & rd_err;
  assign xfer_ok  = rd_stb & rd_ready & ~rd_err;
endmodule

// File: rtl/rvs_seq_fsm.sv
module rvs_seq_fsm
  import rvs_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_gnt,
  input  logic       xfer_ok,
  input  logic       xfer_err,
  input  logic       base_misaligned,
  input  logic       pc_lsb,
  output seq_state_t state,
  output logic       load_cfg,
  output logic       load_ssp,
  output logic       load_pc,
  output logic       start_exec,
  output logic       fof
);
  seq_state_t state_q, state_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_RESET;
    else        state_q <= state_d;
  end

  always_comb begin
    state_d  = state_q;
    load_cfg = 1'b0;
    load_ssp = 1'b0;
    load_pc  = 1'b0;
    case (state_q)
      ST_RESET: begin
        load_cfg = 1'b1;
        state_d  = ST_REQ;
      end
      ST_REQ: begin
        if (bus_gnt) state_d = base_misaligned ? ST_FOF : ST_RD_SSP;
      end
      ST_RD_SSP: begin
        if (xfer_err) state_d = ST_FOF;
        else if (xfer_ok) begin
          load_ssp = 1'b1;
          state_d  = ST_RD_PC;
        end
      end
      ST_RD_PC: begin
        if (xfer_err) state_d = ST_FOF;
        else if (xfer_ok) begin
          if (pc_lsb) state_d = ST_FOF;
          else begin
            load_pc = 1'b1;
            state_d = ST_START;
          end
        end
      end
      ST_START: state_d = ST_RUN;
      ST_RUN:   state_d = ST_RUN;
      ST_FOF:   state_d = ST_FOF;
      default:  state_d = ST_FOF;
    endcase
  end

  assign state      = state_q;
  assign start_exec = (state_q == ST_START);
  assign fof        = (state_q == ST_FOF);
endmodule

// File: rtl/rvs_arch_regs.sv
module rvs_arch_regs
  import rvs_pkg::*;
#(
  parameter int AW = 32,
  parameter int MEM_PORTS = 2,
  parameter logic [AW-1:0] CFG_D0 = '0,
  parameter logic [AW-1:0] CFG_D1 = '0
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  load_cfg,
  input  logic                  load_ssp,
  input  logic                  load_pc,
  input  logic [AW-1:0]         rd_data,
  output logic [SR_W-1:0]       sr_o,
  output logic [AW-1:0]         vbr_o,
  output logic [AW-1:0]         ssp_o,
  output logic [AW-1:0]         pc_o,
  output logic [AW-1:0]         d0_o,
  output logic [AW-1:0]         d1_o,
  output logic [MEM_PORTS-1:0]  mem_en_o
);
  localparam logic [SR_W-1:0] SR_RST = sr_reset_value();

  // control state: forced by reset, not written by this block afterwards
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_o  <= SR_RST;
      vbr_o <= '0;
    end else begin
      sr_o  <= sr_o;
      vbr_o <= vbr_o;
    end
  end

  for (genvar g = 0; g < MEM_PORTS; g++) begin : g_mem_en
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mem_en_o[g] <= 1'b0;
      else        mem_en_o[g] <= mem_en_o[g];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      d0_o <= '0;
      d1_o <= '0;
    end else if (load_cfg) begin
      d0_o <= CFG_D0;
      d1_o <= CFG_D1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        ssp_o <= '0;
    else if (load_ssp) ssp_o <= rd_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pc_o <= '0;
    else if (load_pc) pc_o <= rd_data;
  end
endmodule

// File: rtl/reset_vector_seq.sv
module reset_vector_seq
  import rvs_pkg::*;
#(
  parameter int AW = 32,
  parameter int MEM_PORTS = 2,
  parameter logic [AW-1:0] VEC_BASE = '0,
  parameter logic [AW-1:0] CFG_D0 = 32'hCF20_6009,
  parameter logic [AW-1:0] CFG_D1 = 32'h0011_4120
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_gnt,
  input  logic [AW-1:0]        rd_data,
  input  logic                 rd_ready,
  input  logic                 rd_err,
  output logic                 bus_req,
  output logic                 rd_stb,
  output logic [AW-1:0]        rd_addr,
  output logic [SR_W-1:0]      sr_o,
  output logic [AW-1:0]        vbr_o,
  output logic [AW-1:0]        ssp_o,
  output logic [AW-1:0]        pc_o,
  output logic [AW-1:0]        d0_o,
  output logic [AW-1:0]        d1_o,
  output logic [MEM_PORTS-1:0] mem_en_o,
  output logic                 start_exec,
  output logic                 fof
);
  seq_state_t state;
  logic xfer_ok, xfer_err, base_misaligned;
  logic load_cfg, load_ssp, load_pc;

  rvs_seq_fsm u_fsm (
    .clk             (clk),
    .rst_n           (rst_n),
    .bus_gnt         (bus_gnt),
    .xfer_ok         (xfer_ok),
    .xfer_err        (xfer_err),
    .base_misaligned (base_misaligned),
    .pc_lsb          (rd_data[0]),
    .state           (state),
    .load_cfg        (load_cfg),
    .load_ssp        (load_ssp),
    .load_pc         (load_pc),
    .start_exec      (start_exec),
    .fof             (fof)
  );

  rvs_bus_rd #(.AW(AW), .VEC_BASE(VEC_BASE)) u_bus (
    .state           (state),
    .rd_ready        (rd_ready),
    .rd_err          (rd_err),
    .bus_req         (bus_req),
    .rd_stb          (rd_stb),
    .rd_addr         (rd_addr),
    .xfer_ok         (xfer_ok),
    .xfer_err        (xfer_err),
    .base_misaligned (base_misaligned)
  );

  rvs_arch_regs #(
    .AW(AW), .MEM_PORTS(MEM_PORTS), .CFG_D0(CFG_D0), .CFG_D1(CFG_D1)
  ) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_cfg (load_cfg),
    .load_ssp (load_ssp),
    .load_pc  (load_pc),
    .rd_data  (rd_data),
    .sr_o     (sr_o),
    .vbr_o    (vbr_o),
    .ssp_o    (ssp_o),
    .pc_o     (pc_o),
    .d0_o     (d0_o),
    .d1_o     (d1_o),
    .mem_en_o (mem_en_o)
  );
endmodule

// File: rtl/rvs_checker.sv
module rvs_checker #(
  parameter int AW = 32,
  parameter logic [AW-1:0] VEC_BASE = '0
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_gnt,
  input logic          rd_ready,
  input logic          rd_err,
  input logic [AW-1:0] rd_data,
  input logic          bus_req,
  input logic          rd_stb,
  input logic [AW-1:0] rd_addr,
  input logic [AW-1:0] pc_o,
  input logic          start_exec,
  input logic          fof
);
  AST_HOLD_WHILE_WAITING: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stb && !rd_ready && !rd_err |=> rd_stb && $stable(rd_addr)); // R4
  AST_STB_UNDER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stb |-> bus_req); // R3
  AST_FIRST_ADDR_BASE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_stb) |-> rd_addr == VEC_BASE); // R3
  AST_SECOND_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stb && rd_ready && !rd_err && rd_addr == VEC_BASE |=> rd_stb && rd_addr == VEC_BASE + AW'(4)); // R5
  AST_START_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    start_exec |=> !start_exec); // R6
  AST_START_PC_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
    start_exec |-> !pc_o[0] && !bus_req); // R6
  AST_ERR_TO_FOF: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stb && rd_err |=> fof && !rd_stb); // R7
  AST_FOF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    fof |=> fof && !start_exec); // R7
  AST_ODD_PC_FOF: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stb && rd_ready && !rd_err && rd_addr == VEC_BASE + AW'(4) && rd_data[0] |=> fof); // R8
  AST_NO_BUS_IN_FOF: assert property (@(posedge clk) disable iff (!rst_n)
    fof |-> !bus_req && !rd_stb); // R7
endmodule

bind reset_vector_seq rvs_checker #(.AW(AW), .VEC_BASE(VEC_BASE)) u_rvs_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .bus_gnt    (bus_gnt),
  .rd_ready   (rd_ready),
  .rd_err     (rd_err),
  .rd_data    (rd_data),
  .bus_req    (bus_req),
  .rd_stb     (rd_stb),
  .rd_addr    (rd_addr),
  .pc_o       (pc_o),
  .start_exec (start_exec),
  .fof        (fof)
);

// File: tb/test_reset_vector_seq.sv
`timescale 1ns/1ps
module test_reset_vector_seq;
  localparam int AW = 32;
  localparam logic [31:0] D0V = 32'hCF20_6009;
  localparam logic [31:0] D1V = 32'h0011_4120;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n = 1'b0;
  logic bus_gnt = 1'b0, rd_ready = 1'b0, rd_err = 1'b0;
  logic [31:0] rd_data = '0;

  logic bus_req, rd_stb, start_exec, fof;
  logic [31:0] rd_addr, vbr_o, ssp_o, pc_o, d0_o, d1_o;
  logic [15:0] sr_o;
  logic [1:0]  mem_en_o;

  logic m_bus_req, m_rd_stb, m_start, m_fof;
  logic [31:0] m_addr, m_vbr, m_ssp, m_pc, m_d0, m_d1;
  logic [15:0] m_sr;
  logic [1:0]  m_mem;

  reset_vector_seq #(.CFG_D0(D0V), .CFG_D1(D1V)) i_reset_vector_seq (
    .clk(clk), .rst_n(rst_n), .bus_gnt(bus_gnt), .rd_data(rd_data),
    .rd_ready(rd_ready), .rd_err(rd_err), .bus_req(bus_req), .rd_stb(rd_stb),
    .rd_addr(rd_addr), .sr_o(sr_o), .vbr_o(vbr_o), .ssp_o(ssp_o), .pc_o(pc_o),
    .d0_o(d0_o), .d1_o(d1_o), .mem_en_o(mem_en_o), .start_exec(start_exec),
    .fof(fof));

  reset_vector_seq #(.VEC_BASE(32'h0000_0002)) i_reset_vector_seq_misal (
    .clk(clk), .rst_n(rst_n), .bus_gnt(bus_gnt), .rd_data(rd_data),
    .rd_ready(rd_ready), .rd_err(rd_err), .bus_req(m_bus_req), .rd_stb(m_rd_stb),
    .rd_addr(m_addr), .sr_o(m_sr), .vbr_o(m_vbr), .ssp_o(m_ssp), .pc_o(m_pc),
    .d0_o(m_d0), .d1_o(m_d1), .mem_en_o(m_mem), .start_exec(m_start),
    .fof(m_fof));

  int checks = 0;
  int errors = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic idle_bus();
    bus_gnt = 1'b0; rd_ready = 1'b0; rd_err = 1'b0; rd_data = '0;
  endtask

  // holds reset, checks forced values, then releases and checks R2
  task automatic reset_and_release();
    idle_bus();
    cyc();
    rst_n = 1'b0;
    #1;
    chk("R10 async bus_req", {31'b0, bus_req}, 32'h0);
    chk("R10 async fof", {31'b0, fof}, 32'h0);
    cyc(2);
    chk("R1 sr", {16'b0, sr_o}, 32'h0000_2700);
    chk("R1 vbr", vbr_o, 32'h0);
    chk("R1 ssp/pc", ssp_o | pc_o, 32'h0);
    chk("R1 d0/d1", d0_o | d1_o, 32'h0);
    chk("R1 mem_en", {30'b0, mem_en_o}, 32'h0);
    chk("R1 strobes", {28'b0, bus_req, rd_stb, start_exec, fof}, 32'h0);
    rst_n = 1'b1;
    cyc();
    chk("R2 d0", d0_o, D0V);
    chk("R2 d1", d1_o, D1V);
    chk("R2 bus_req", {31'b0, bus_req}, 32'h1);
    chk("R2 no read", {31'b0, rd_stb}, 32'h0);
  endtask

  task automatic grant_and_first();
    cyc(2);
    chk("R3 waits for grant", {30'b0, bus_req, rd_stb}, 32'h2);
    bus_gnt = 1'b1;
    cyc();
    chk("R3 first read strobe", {31'b0, rd_stb}, 32'h1);
    chk("R3 first read addr", rd_addr, 32'h0);
  endtask

  task automatic t_normal(input logic [31:0] sp, input logic [31:0] pcv, input int wait_n);
    reset_and_release();
    grant_and_first();
    for (int i = 0; i < wait_n; i++) begin
      cyc();
      chk("R4 hold addr", rd_addr, 32'h0);
      chk("R4 hold stb", {31'b0, rd_stb}, 32'h1);
    end
    rd_ready = 1'b1; rd_data = sp;
    cyc();
    rd_ready = 1'b0; rd_data = 32'hDEAD_BEEF;
    chk("R5 ssp loaded", ssp_o, sp);
    chk("R5 second addr", rd_addr, 32'h4);
    chk("R5 stb continuous", {31'b0, rd_stb}, 32'h1);
    cyc(wait_n);
    chk("R4 hold second addr", rd_addr, 32'h4);
    chk("R5 ssp unchanged while waiting", ssp_o, sp);
    rd_ready = 1'b1; rd_data = pcv;
    cyc();
    rd_ready = 1'b0; rd_data = 32'h5555_5555;
    chk("R6 start", {31'b0, start_exec}, 32'h1);
    chk("R6 pc", pc_o, pcv);
    chk("R6 bus released", {30'b0, bus_req, rd_stb}, 32'h0);
    chk("R11 sr", {16'b0, sr_o}, 32'h0000_2700);
    chk("R11 vbr/mem", vbr_o | {30'b0, mem_en_o}, 32'h0);
    cyc();
    chk("R6 start one cycle", {31'b0, start_exec}, 32'h0);
    rd_ready = 1'b1;
    cyc(2);
    chk("R6 idle after start", {29'b0, start_exec, bus_req, rd_stb}, 32'h0);
    chk("R6 pc kept", pc_o, pcv);
    idle_bus();
  endtask

  task automatic t_err_first();
    reset_and_release();
    grant_and_first();
    rd_err = 1'b1; rd_ready = 1'b1; rd_data = 32'h1234_5678;
    cyc();
    rd_err = 1'b0; rd_ready = 1'b0;
    chk("R7 fof after first err", {31'b0, fof}, 32'h1);
    chk("R7 bus dropped", {30'b0, bus_req, rd_stb}, 32'h0);
    chk("R7 ssp unchanged", ssp_o, 32'h0);
    cyc(4);
    chk("R7 fof sticky", {30'b0, fof, start_exec}, 32'h2);
    idle_bus();
  endtask

  task automatic t_err_second();
    reset_and_release();
    grant_and_first();
    rd_ready = 1'b1; rd_data = 32'h2000_4000;
    cyc();
    rd_ready = 1'b0; rd_err = 1'b1; rd_data = 32'h0000_0100;
    cyc();
    rd_err = 1'b0;
    chk("R7 fof after second err", {31'b0, fof}, 32'h1);
    chk("R7 pc unchanged", pc_o, 32'h0);
    chk("R7 ssp retained", ssp_o, 32'h2000_4000);
    cyc(3);
    chk("R7 no start", {31'b0, start_exec}, 32'h0);
    idle_bus();
  endtask

  task automatic t_odd_pc();
    reset_and_release();
    grant_and_first();
    rd_ready = 1'b1; rd_data = 32'h2000_0000;
    cyc();
    rd_data = 32'h0000_0401;
    cyc();
    rd_ready = 1'b0;
    chk("R8 odd pc fof", {31'b0, fof}, 32'h1);
    chk("R8 pc not loaded", pc_o, 32'h0);
    chk("R8 no start", {31'b0, start_exec}, 32'h0);
    idle_bus();
  endtask

  task automatic t_misaligned();
    reset_and_release();
    chk("R9 misal requests", {31'b0, m_bus_req}, 32'h1);
    bus_gnt = 1'b1;
    cyc();
    chk("R9 misal fof", {31'b0, m_fof}, 32'h1);
    chk("R9 misal no strobe", {31'b0, m_rd_stb}, 32'h0);
    cyc(3);
    chk("R9 misal stays", {30'b0, m_fof, m_rd_stb}, 32'h2);
    idle_bus();
  endtask

  task automatic t_abort();
    reset_and_release();
    grant_and_first();
    rd_ready = 1'b1; rd_data = 32'h3000_0000;
    cyc();
    rd_ready = 1'b0;
    // mid second read: abort
    rst_n = 1'b0;
    #1;
    chk("R10 abort stb", {30'b0, bus_req, rd_stb}, 32'h0);
    chk("R10 abort ssp", ssp_o, 32'h0);
    chk("R10 abort d0", d0_o, 32'h0);
    cyc(2);
    rst_n = 1'b1;
    idle_bus();
    cyc();
    chk("R10 restart request", {31'b0, bus_req}, 32'h1);
    bus_gnt = 1'b1;
    cyc();
    chk("R10 restart first addr", rd_addr, 32'h0);
    chk("R10 restart strobe", {31'b0, rd_stb}, 32'h1);
    idle_bus();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    cyc(2);
    t_normal(32'h2000_3FF0, 32'h0000_0410, 0);
    t_normal(32'h1FFF_FFFC, 32'h0003_0002, 3);
    t_err_first();
    t_err_second();
    t_odd_pc();
    t_misaligned();
    t_abort();
    t_normal(32'hA5A5_A5A4, 32'hFFFF_FFFE, 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule